// File: doc/BRIEF.md
# Two-Wide Register Rename Unit

This block renames up to two instructions per cycle for an out-of-order core that keeps all values, committed and speculative, in one shared physical register file. It keeps a speculative map from each architectural register to a physical tag, a committed copy of that map, and a circular queue of free physical tags. For every renamed instruction it returns both source tags and, for a register-writing instruction, a freshly allocated destination tag plus the tag that destination was mapped to until now. That stale tag travels with the instruction to the reorder buffer. It comes back on the commit port once the instruction retires, and only then is it put back into the free queue.

Within a group the lanes follow program order, lane 0 oldest. A later lane that reads or overwrites a register written by an earlier lane of the same group sees the earlier lane's new tag. If the free queue cannot cover every writer in the group, the whole group stalls. A flush copies the committed map back over the speculative map and rebuilds the free queue from the tags that the committed map does not use.

Top module: `reg_rename`

## Requirements
- R1: Each valid lane with its write flag set takes one new destination tag from the head of the free queue, in lane order: lane 0 takes the head entry and lane 1 the next one. Tags given out in one group are all distinct.
- R2: A source with no earlier writer in the same group gets the tag that the speculative map currently holds for that architectural register.
- R3: A writing lane reports, with its previous-valid flag set to 1, the tag its destination was mapped to before the lane renamed, and that tag differs from the new one.
- R4: A valid lane with its write flag clear sets its previous-valid flag to 0 and takes no tag, so the next writer receives the tag this lane would have taken.
- R5: When an earlier lane of the same group writes architectural register r, a later lane's source r and its previous tag for destination r equal the earlier lane's new tag.
- R6: The group stalls (ren_stall = 1) when the number of writing lanes exceeds the number of free tags. A stalled group changes neither map nor queue, and the free count holds if there is no commit.
- R7: Each commit lane with its valid bit set writes its tag into the committed map and appends its stale tag to the tail of the free queue, lane 0 before lane 1. Freed tags are handed out after the tags already queued.
- R8: On flush the speculative map becomes the committed map, including commits presented in the same cycle, and the rename group of that cycle is ignored.
- R9: After a flush the free queue holds exactly the tags absent from the committed map, in ascending order, so the free count equals physical minus architectural registers (8).
- R10: After reset architectural register i maps to physical tag i, and the free queue holds tags 8 to 15 in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Restore the speculative state from the committed map |
| ren_valid | input | 2 | Lane holds an instruction |
| ren_wr | input | 2 | Lane writes a destination register |
| ren_dst | input | 2x3 | Destination architectural register per lane |
| ren_src1 | input | 2x3 | First source architectural register per lane |
| ren_src2 | input | 2x3 | Second source architectural register per lane |
| ren_stall | output | 1 | Group cannot rename this cycle |
| out_src1 | output | 2x4 | Renamed first source tag per lane |
| out_src2 | output | 2x4 | Renamed second source tag per lane |
| out_dst | output | 2x4 | Newly allocated destination tag per lane |
| out_prev | output | 2x4 | Previous mapping of the destination per lane |
| out_prev_valid | output | 2 | Lane allocated a tag and out_prev is meaningful |
| cmt_valid | input | 2 | Commit lane retires a register-writing instruction |
| cmt_arch | input | 2x3 | Destination architectural register of the retiring instruction |
| cmt_tag | input | 2x4 | Tag the retiring instruction wrote |
| cmt_prev | input | 2x4 | Stale tag to return to the free queue |

## Verification
A read-only pass walks every architectural register through every source slot straight after reset, which separates the reset map from any off-by-one in the table read. A full 8x8 sweep pairs every lane-0 destination with every lane-1 destination and source. This tells intra-group forwarding apart from a plain table read, for sources and previous tags alike. Random traffic is then run in phases with commit rates from none to every cycle and with occasional flushes. Starved phases exercise the stall decision and free-queue order, while busy phases recycle tags through the tail and check that a flush rebuilds the queue from the committed map.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
    parameter int unsigned NUM_ARCH  = 8;
    parameter int unsigned NUM_PHYS  = 16;
    parameter int unsigned NUM_LANES = 2;

    localparam int unsigned AREG_W     = $clog2(NUM_ARCH);
    localparam int unsigned TAG_W      = $clog2(NUM_PHYS);
    localparam int unsigned FL_DEPTH   = NUM_PHYS - NUM_ARCH;
    localparam int unsigned FL_PTR_W   = (FL_DEPTH > 1) ? $clog2(FL_DEPTH) : 1;
    localparam int unsigned FL_CNT_W   = $clog2(FL_DEPTH + 1);
    localparam int unsigned LANE_CNT_W = $clog2(NUM_LANES + 1);
    localparam int unsigned LANE_IDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    typedef logic [AREG_W-1:0]   areg_t;
    typedef logic [TAG_W-1:0]    ptag_t;
    typedef logic [FL_PTR_W-1:0] flptr_t;
    typedef logic [FL_CNT_W-1:0] flcnt_t;
endpackage

// File: rtl/rn_free_list.sv
`timescale 1ns/1ps
module rn_free_list
    import rn_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANE_CNT_W-1:0]         pop_n,
    input  logic [NUM_LANES-1:0]          push_v,
    input  ptag_t [NUM_LANES-1:0]         push_tag,
    input  logic                          rebuild,
    input  logic [NUM_PHYS-1:0]           used_mask,
    output ptag_t [NUM_LANES-1:0]         peek_tag,
    output flcnt_t                        count
);
    typedef struct packed {
        ptag_t [FL_DEPTH-1:0] slot;
        flptr_t               head;
        flptr_t               tail;
        flcnt_t               count;
    } fl_state_t;

    fl_state_t st_d, st_q;

    function automatic flptr_t wrap(input int unsigned v);
        return flptr_t'(v % FL_DEPTH);
    endfunction

    function automatic fl_state_t reset_state();
        fl_state_t s;
        s = '0;
        for (int unsigned i = 0; i < FL_DEPTH; i++) begin
            s.slot[i] = ptag_t'(NUM_ARCH + i);
        end
        s.count = flcnt_t'(FL_DEPTH);
        return s;
    endfunction

    // next-state: either a rebuild from the committed map or pop/push
    always_comb begin
        int unsigned pushes;
        int unsigned fill;
        st_d   = st_q;
        pushes = 0;
        fill   = 0;
        if (rebuild) begin
            for (int unsigned t = 0; t < NUM_PHYS; t++) begin
                if (!used_mask[TAG_W'(t)] && fill < FL_DEPTH) begin
                    st_d.slot[flptr_t'(fill)] = ptag_t'(t);
                    fill++;
                end
            end
            st_d.head  = '0;
            st_d.tail  = wrap(fill);
            st_d.count = flcnt_t'(fill);
        end else begin
            for (int unsigned i = 0; i < NUM_LANES; i++) begin
                if (push_v[i]) begin
                    st_d.slot[wrap(32'(st_q.tail) + pushes)] = push_tag[i];
                    pushes++;
                end
            end
            st_d.head  = wrap(32'(st_q.head) + 32'(pop_n));
            st_d.tail  = wrap(32'(st_q.tail) + pushes);
            st_d.count = flcnt_t'(32'(st_q.count) + pushes - 32'(pop_n));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int unsigned i = 0; i < NUM_LANES; i++) begin
            peek_tag[i] = st_q.slot[wrap(32'(st_q.head) + i)];
        end
        count = st_q.count;
    end
endmodule

// File: rtl/rn_map_table.sv
`timescale 1ns/1ps
module rn_map_table
    import rn_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LANES-1:0]   wr_en,
    input  areg_t [NUM_LANES-1:0]  wr_arch,
    input  ptag_t [NUM_LANES-1:0]  wr_tag,
    input  logic [NUM_LANES-1:0]   cm_en,
    input  areg_t [NUM_LANES-1:0]  cm_arch,
    input  ptag_t [NUM_LANES-1:0]  cm_tag,
    input  logic                   restore,
    output ptag_t [NUM_ARCH-1:0]   spec_map,
    output logic [NUM_PHYS-1:0]    used_next
);
    typedef struct packed {
        ptag_t [NUM_ARCH-1:0] spec;
        ptag_t [NUM_ARCH-1:0] cmt;
    } map_state_t;

    map_state_t st_d, st_q;

    function automatic map_state_t reset_state();
        map_state_t s;
        for (int unsigned a = 0; a < NUM_ARCH; a++) begin
            s.spec[a] = ptag_t'(a);
            s.cmt[a]  = ptag_t'(a);
        end
        return s;
    endfunction

    // later lanes overwrite earlier ones: program order within a group
    always_comb begin
        st_d = st_q;
        for (int unsigned i = 0; i < NUM_LANES; i++) begin
            if (cm_en[i]) begin
                st_d.cmt[cm_arch[i]] = cm_tag[i];
            end
        end
        for (int unsigned i = 0; i < NUM_LANES; i++) begin
            if (wr_en[i]) begin
                st_d.spec[wr_arch[i]] = wr_tag[i];
            end
        end
        if (restore) begin
            st_d.spec = st_d.cmt;
        end
        used_next = '0;
        for (int unsigned a = 0; a < NUM_ARCH; a++) begin
            used_next[st_d.cmt[a]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign spec_map = st_q.spec;
endmodule

// File: rtl/reg_rename.sv
`timescale 1ns/1ps
module reg_rename
    import rn_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                flush,
    input  logic [NUM_LANES-1:0]                ren_valid,
    input  logic [NUM_LANES-1:0]                ren_wr,
    input  logic [NUM_LANES-1:0][AREG_W-1:0]    ren_dst,
    input  logic [NUM_LANES-1:0][AREG_W-1:0]    ren_src1,
    input  logic [NUM_LANES-1:0][AREG_W-1:0]    ren_src2,
    output logic                                ren_stall,
    output logic [NUM_LANES-1:0][TAG_W-1:0]     out_src1,
    output logic [NUM_LANES-1:0][TAG_W-1:0]     out_src2,
    output logic [NUM_LANES-1:0][TAG_W-1:0]     out_dst,
    output logic [NUM_LANES-1:0][TAG_W-1:0]     out_prev,
    output logic [NUM_LANES-1:0]                out_prev_valid,
    input  logic [NUM_LANES-1:0]                cmt_valid,
    input  logic [NUM_LANES-1:0][AREG_W-1:0]    cmt_arch,
    input  logic [NUM_LANES-1:0][TAG_W-1:0]     cmt_tag,
    input  logic [NUM_LANES-1:0][TAG_W-1:0]     cmt_prev
);
    ptag_t [NUM_ARCH-1:0]    spec_map;
    logic [NUM_PHYS-1:0]     used_next;
    ptag_t [NUM_LANES-1:0]   peek_tag;
    flcnt_t                  fl_count;
    logic [NUM_LANES-1:0]    alloc;
    logic [LANE_CNT_W-1:0]   need;
    logic [LANE_CNT_W-1:0]   pop_n;
    logic                    fire;
    logic [NUM_LANES-1:0]    map_wr;
    logic [NUM_LANES-1:0]    fl_push;

    // rename group: table read, allocation and same-group forwarding
    always_comb begin
        int unsigned slot;
        alloc = ren_valid & ren_wr;
        need  = '0;
        for (int unsigned i = 0; i < NUM_LANES; i++) begin
            need = need + LANE_CNT_W'(alloc[i]);
        end
        ren_stall = (32'(need) > 32'(fl_count));
        fire      = !ren_stall && !flush;
        slot      = 0;
        for (int k = 0; k < NUM_LANES; k++) begin
            out_dst[k] = peek_tag[LANE_IDX_W'(slot)];
            if (alloc[k]) begin
                slot++;
            end
            out_src1[k] = spec_map[ren_src1[k]];
            out_src2[k] = spec_map[ren_src2[k]];
            out_prev[k] = spec_map[ren_dst[k]];
            for (int j = 0; j < k; j++) begin
                if (alloc[j] && ren_dst[j] == ren_src1[k]) out_src1[k] = out_dst[j];
                if (alloc[j] && ren_dst[j] == ren_src2[k]) out_src2[k] = out_dst[j];
                if (alloc[j] && ren_dst[j] == ren_dst[k])  out_prev[k] = out_dst[j];
            end
            out_prev_valid[k] = alloc[k];
        end
        pop_n   = fire ? need : '0;
        map_wr  = fire ? alloc : '0;
        fl_push = flush ? '0 : cmt_valid;
    end

    rn_map_table u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (map_wr),
        .wr_arch   (ren_dst),
        .wr_tag    (out_dst),
        .cm_en     (cmt_valid),
        .cm_arch   (cmt_arch),
        .cm_tag    (cmt_tag),
        .restore   (flush),
        .spec_map  (spec_map),
        .used_next (used_next)
    );

    rn_free_list u_fl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_n     (pop_n),
        .push_v    (fl_push),
        .push_tag  (cmt_prev),
        .rebuild   (flush),
        .used_mask (used_next),
        .peek_tag  (peek_tag),
        .count     (fl_count)
    );
endmodule

// File: rtl/rn_checker.sv
`timescale 1ns/1ps
module rn_checker
    import rn_pkg::*;
(
    input logic                             clk,
    input logic                             rst_n,
    input logic                             flush,
    input logic [NUM_LANES-1:0]             ren_valid,
    input logic [NUM_LANES-1:0]             ren_wr,
    input logic [NUM_LANES-1:0][AREG_W-1:0] ren_dst,
    input logic [NUM_LANES-1:0][AREG_W-1:0] ren_src1,
    input logic                             ren_stall,
    input logic [NUM_LANES-1:0][TAG_W-1:0]  out_src1,
    input logic [NUM_LANES-1:0][TAG_W-1:0]  out_dst,
    input logic [NUM_LANES-1:0][TAG_W-1:0]  out_prev,
    input logic [NUM_LANES-1:0]             out_prev_valid,
    input logic [NUM_LANES-1:0]             cmt_valid,
    input flcnt_t                           fl_count
);
    logic go;
    assign go = !ren_stall && !flush;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fl_count) <= FL_DEPTH); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ren_stall && !flush && !(|cmt_valid) |=> $stable(fl_count)); // R6
    AST_FLUSH_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> 32'(fl_count) == FL_DEPTH); // R9
    AST_FRESH_DST: assert property (@(posedge clk) disable iff (!rst_n)
        go && ren_valid[0] && ren_wr[0] |-> out_dst[0] != out_prev[0]); // R3

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        AST_NO_PREV: assert property (@(posedge clk) disable iff (!rst_n)
            ren_valid[k] && !ren_wr[k] |-> !out_prev_valid[k]); // R4
    end

    if (NUM_LANES > 1) begin : g_pair
        AST_DISTINCT_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
            go && ren_valid[0] && ren_wr[0] && ren_valid[1] && ren_wr[1]
            |-> out_dst[0] != out_dst[1]); // R1
        AST_BYPASS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
            go && ren_valid[0] && ren_wr[0] && ren_valid[1] && ren_src1[1] == ren_dst[0]
            |-> out_src1[1] == out_dst[0]); // R5
    end
endmodule

bind reg_rename rn_checker u_chk (.*);

// File: tb/test_reg_rename.sv
`timescale 1ns/1ps
module test_reg_rename;
    import rn_pkg::*;

    typedef struct {
        int arch;
        int tag;
        int prev;
    } rob_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic [NUM_LANES-1:0]             ren_valid = '0;
    logic [NUM_LANES-1:0]             ren_wr = '0;
    logic [NUM_LANES-1:0][AREG_W-1:0] ren_dst = '0;
    logic [NUM_LANES-1:0][AREG_W-1:0] ren_src1 = '0;
    logic [NUM_LANES-1:0][AREG_W-1:0] ren_src2 = '0;
    logic                             ren_stall;
    logic [NUM_LANES-1:0][TAG_W-1:0]  out_src1;
    logic [NUM_LANES-1:0][TAG_W-1:0]  out_src2;
    logic [NUM_LANES-1:0][TAG_W-1:0]  out_dst;
    logic [NUM_LANES-1:0][TAG_W-1:0]  out_prev;
    logic [NUM_LANES-1:0]             out_prev_valid;
    logic [NUM_LANES-1:0]             cmt_valid = '0;
    logic [NUM_LANES-1:0][AREG_W-1:0] cmt_arch = '0;
    logic [NUM_LANES-1:0][TAG_W-1:0]  cmt_tag = '0;
    logic [NUM_LANES-1:0][TAG_W-1:0]  cmt_prev = '0;

    int   spec_m[NUM_ARCH];
    int   cmap_m[NUM_ARCH];
    int   free_m[$];
    rob_t rob[$];
    int   checks = 0;
    int   fails = 0;
    int   ncmt = 0;
    bit   finished = 0;
    string phase = "R10";

    always #2.5 clk = ~clk;

    reg_rename i_reg_rename (.*);

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic pick_commits(input int pct);
        cmt_valid = '0;
        ncmt = 0;
        for (int k = 0; k < NUM_LANES; k++) begin
            if (rob.size() > ncmt && int'($urandom % 100) < pct) begin
                cmt_valid[k] = 1'b1;
                cmt_arch[k]  = AREG_W'(rob[ncmt].arch);
                cmt_tag[k]   = TAG_W'(rob[ncmt].tag);
                cmt_prev[k]  = TAG_W'(rob[ncmt].prev);
                ncmt++;
            end else begin
                break;
            end
        end
    endtask

    task automatic stim_random(input int wr_pct);
        for (int k = 0; k < NUM_LANES; k++) begin
            ren_valid[k] = ($urandom % 4) != 0;
            ren_wr[k]    = int'($urandom % 100) < wr_pct;
            ren_dst[k]   = AREG_W'($urandom % NUM_ARCH);
            ren_src1[k]  = AREG_W'($urandom % NUM_ARCH);
            ren_src2[k]  = AREG_W'($urandom % NUM_ARCH);
        end
        if ($urandom % 3 == 0) ren_src1[1] = ren_dst[0];
        if ($urandom % 4 == 0) ren_dst[1] = ren_dst[0];
    endtask

    // one cycle: inputs already driven after a falling edge
    task automatic cycle(input bit do_flush);
        int  need;
        bit  exp_stall;
        bit  wrote[NUM_ARCH];
        int  a1, a2, ad, nt, found;
        rob_t e;
        flush = do_flush;
        #1;
        need = 0;
        for (int k = 0; k < NUM_LANES; k++) need += int'(ren_valid[k] && ren_wr[k]);
        exp_stall = need > free_m.size();
        for (int a = 0; a < NUM_ARCH; a++) wrote[a] = 1'b0;
        if (!do_flush) begin
            chk($sformatf("R6 stall %s", phase), int'(ren_stall), int'(exp_stall));
            if (!exp_stall) begin
                for (int k = 0; k < NUM_LANES; k++) begin
                    if (ren_valid[k]) begin
                        a1 = int'(ren_src1[k]);
                        a2 = int'(ren_src2[k]);
                        ad = int'(ren_dst[k]);
                        chk($sformatf("%s src1 lane%0d %s", wrote[a1] ? "R5" : "R2", k, phase),
                            int'(out_src1[k]), spec_m[a1]);
                        chk($sformatf("%s src2 lane%0d %s", wrote[a2] ? "R5" : "R2", k, phase),
                            int'(out_src2[k]), spec_m[a2]);
                        if (ren_wr[k]) begin
                            chk($sformatf("R3 prev_valid lane%0d", k), int'(out_prev_valid[k]), 1);
                            chk($sformatf("%s prev lane%0d %s", wrote[ad] ? "R5" : "R3", k, phase),
                                int'(out_prev[k]), spec_m[ad]);
                            nt = free_m.pop_front();
                            chk($sformatf("R1 dst lane%0d %s", k, phase), int'(out_dst[k]), nt);
                            rob.push_back('{ad, nt, spec_m[ad]});
                            spec_m[ad] = nt;
                            wrote[ad]  = 1'b1;
                        end else begin
                            chk($sformatf("R4 prev_valid lane%0d", k), int'(out_prev_valid[k]), 0);
                        end
                    end
                end
            end
        end
        for (int i = 0; i < ncmt; i++) begin
            e = rob.pop_front();
            cmap_m[e.arch] = e.tag;
            if (!do_flush) free_m.push_back(e.prev);
        end
        if (do_flush) begin
            for (int a = 0; a < NUM_ARCH; a++) spec_m[a] = cmap_m[a];
            free_m.delete();
            for (int t = 0; t < NUM_PHYS; t++) begin
                found = 0;
                for (int a = 0; a < NUM_ARCH; a++) if (cmap_m[a] == t) found = 1;
                if (found == 0) free_m.push_back(t);
            end
            rob.delete();
            phase = "R8/R9";
        end else if (phase == "R8/R9") begin
            phase = "R7";
        end
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int pct;
        for (int a = 0; a < NUM_ARCH; a++) begin
            spec_m[a] = a;
            cmap_m[a] = a;
        end
        for (int t = NUM_ARCH; t < NUM_PHYS; t++) free_m.push_back(t);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: read-only sweep of the reset map
        ren_valid = '1;
        ren_wr    = '0;
        for (int a = 0; a < NUM_ARCH; a++) begin
            for (int k = 0; k < NUM_LANES; k++) begin
                ren_src1[k] = AREG_W'((a + k) % NUM_ARCH);
                ren_src2[k] = AREG_W'((a + k + 1) % NUM_ARCH);
                ren_dst[k]  = AREG_W'(a);
            end
            pick_commits(0);
            cycle(1'b0);
        end

        // R5: every lane-0 destination against every lane-1 register
        for (int a = 0; a < NUM_ARCH; a++) begin
            for (int b = 0; b < NUM_ARCH; b++) begin
                ren_valid   = '1;
                ren_wr      = '1;
                ren_dst[0]  = AREG_W'(a);
                ren_src1[0] = AREG_W'(b);
                ren_src2[0] = AREG_W'(a);
                ren_dst[1]  = AREG_W'(b);
                ren_src1[1] = AREG_W'(a);
                ren_src2[1] = AREG_W'(b);
                pick_commits(100);
                cycle(1'b0);
                phase = "R7";
            end
        end

        // R6: starve the free queue, then R8/R9: flush
        for (int i = 0; i < 6; i++) begin
            ren_valid = '1;
            ren_wr    = '1;
            pick_commits(0);
            cycle(1'b0);
        end
        pick_commits(100);
        cycle(1'b1);

        for (int p = 0; p < 6; p++) begin
            case (p)
                0: pct = 60;
                1: pct = 0;
                2: pct = 90;
                3: pct = 30;
                4: pct = 100;
                default: pct = 50;
            endcase
            for (int i = 0; i < 500; i++) begin
                stim_random(70);
                pick_commits(pct);
                cycle(($urandom % 40) == 0);
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule